// File: doc/BRIEF.md
# Peripheral Bank Decoder with Protection

This block turns each request on an external peripheral bus (address, direction, valid) into at most one chip-select among eight configurable banks. Every bank has a configuration word with a base address, a power-of-two size, an access permission and a data bus width. The block compares the top twelve address bits against each bank's base, ignoring the base bits that fall inside the bank's size. It then asserts the chip-select of the single matching bank and reports that bank's bus width on the same cycle.

Two kinds of fault are caught. If more than one enabled bank claims an address, the configuration is treated as broken and the access is dropped. If the access direction is not allowed by the bank's permission, the access is also dropped. In both cases a one-cycle error pulse goes to the requester, where it can serve as a machine check or an interrupt. The first fault's address and type stay in an error log until software clears it, and later faults only set an overflow flag.

Top module: `periph_bank_decoder`

## Requirements
- R1: After reset, all chip-selects, the bus width output, the error pulse, the logged error address and the error status are zero.
- R2: A valid request that hits exactly one permitted bank asserts only that bank's chip-select, one clock after the request is sampled, together with that bank's 2-bit width code (00 = 8-bit, 01 = 16-bit, 10 = 32-bit). When no chip-select is asserted, the width output is 00.
- R3: A bank of size code s (0..7) covers 1 MB << s. It matches when address bits [31:20+s] equal base bits [11:s]. Base bits below s are ignored.
- R4: A bank with usage code 00 never matches. An address that no enabled bank matches asserts no chip-select and no error.
- R5: When two or more enabled banks match, no chip-select is asserted and the error pulse is raised. The fault is logged with type 01 and the index of the lowest matching bank.
- R6: A write to a bank with usage 01 (read-only) asserts no chip-select and raises the error pulse. It is logged with type 10 and that bank's index.
- R7: A read from a bank with usage 10 (write-only) asserts no chip-select and raises the error pulse. It is logged with type 11 and that bank's index. Usage 11 permits both directions.
- R8: The error status is {overflow bit [5], bank index [4:2], type [1:0]}. The first fault's full address and status are held. Any later fault before a clear only sets the overflow bit.
- R9: A configuration write with select value 8 clears the error address and status. Select values 0..7 load the 19-bit word {base[18:7], size[6:4], usage[3:2], width[1:0]} into that bank, and the new word applies from the next cycle. A fault in the same cycle as a clear is logged as a first fault.
- R10: While the request valid input is low, no chip-select and no error pulse follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 4 | Bank index 0..7, or 8 to clear the error log |
| cfg_wdata_i | input | 19 | Bank configuration word |
| req_valid_i | input | 1 | Request valid |
| req_we_i | input | 1 | Request is a write (1) or read (0) |
| req_addr_i | input | 32 | Request byte address |
| cs_o | output | 8 | Registered one-hot chip-selects |
| bus_width_o | output | 2 | Width code of the selected bank |
| err_o | output | 1 | One-cycle error pulse to the requester |
| err_addr_o | output | 32 | Address of the first logged fault |
| err_status_o | output | 6 | {overflow, bank index, type} of the logged fault |

## Verification
The bench probes the edges of masked ranges: the first address past a 1 MB bank, the addresses just below a 16 MB bank and a 2 MB bank, and the top of a 128 MB bank. A decoder that ignored the size mask, or masked the wrong bits, would select a bank there or miss one. Two banks share a base to check that an overlap drops the access and names the lower bank. A design that fell back to priority selection would assert a chip-select instead. Read-only and write-only banks are hit in both directions, and the log is filled by several faults before it is cleared. A log that overwrote on each fault, or never set overflow, would show the wrong address or status.

// File: rtl/pbd_pkg.sv
package pbd_pkg;

    localparam int BASE_W = 12;
    localparam int SIZE_W = 3;
    localparam int BW_W   = 2;

    typedef enum logic [1:0] {
        USE_OFF = 2'b00,
        USE_RO  = 2'b01,
        USE_WO  = 2'b10,
        USE_RW  = 2'b11
    } usage_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_OVERLAP = 2'b01,
        FLT_WPROT   = 2'b10,
        FLT_RPROT   = 2'b11
    } fault_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [SIZE_W-1:0] size;
        usage_e            usage;
        logic [BW_W-1:0]   width;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

endpackage

// File: rtl/pbd_bank_match.sv
module pbd_bank_match
    import pbd_pkg::*;
(
    input  logic [BASE_W-1:0] base_i,
    input  logic [SIZE_W-1:0] size_i,
    input  usage_e            usage_i,
    input  logic [BASE_W-1:0] addr_hi_i,
    output logic              hit_o
);

    logic [BASE_W-1:0] care;

    always_comb begin
        care  = {BASE_W{1'b1}} << size_i;
        hit_o = (usage_i != USE_OFF) && (((addr_hi_i ^ base_i) & care) == '0);
    end

endmodule

// File: rtl/pbd_resolve.sv
module pbd_resolve #(
    parameter int NB    = 8,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic [NB-1:0]    hits_i,
    output logic             any_o,
    output logic             multi_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        any_o   = |hits_i;
        multi_o = ($countones(hits_i) > 1);
        idx_o   = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (hits_i[i]) idx_o = IDX_W'(i);
        end
    end

endmodule

// File: rtl/pbd_err_log.sv
module pbd_err_log
    import pbd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 3,
    localparam int ST_W  = IDX_W + 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              evt_i,
    input  fault_e            code_i,
    input  logic [IDX_W-1:0]  bank_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [ST_W-1:0]   err_status_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              ovf;
        logic [IDX_W-1:0]  bank;
        fault_e            code;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (clr_i) log_d = '0;
        if (evt_i) begin
            if (log_d.code == FLT_NONE) begin
                log_d.addr = addr_i;
                log_d.bank = bank_i;
                log_d.code = code_i;
            end else begin
                log_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) log_q <= '0;
        else         log_q <= log_d;
    end

    assign err_addr_o   = log_q.addr;
    assign err_status_o = {log_q.ovf, log_q.bank, log_q.code};

    a_r8_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_status_o[1:0] != 2'b00 && !clr_i) |=> $stable(err_addr_o));

    a_r8_hold_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_status_o[1:0] != 2'b00 && !clr_i) |=> $stable(err_status_o[ST_W-2:0]));

    a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !evt_i) |=> (err_status_o == '0));

endmodule

// File: rtl/periph_bank_decoder.sv
module periph_bank_decoder
    import pbd_pkg::*;
#(
    parameter int NB     = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1,
    localparam int SEL_W = $clog2(NB + 1),
    localparam int ST_W  = IDX_W + 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [SEL_W-1:0]  cfg_sel_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    input  logic              req_valid_i,
    input  logic              req_we_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic [NB-1:0]     cs_o,
    output logic [BW_W-1:0]   bus_width_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] err_addr_o,
    output logic [ST_W-1:0]   err_status_o
);

    localparam logic [SEL_W-1:0] CLR_SEL = SEL_W'(NB);

    typedef struct packed {
        bank_cfg_t [NB-1:0] cfg;
        logic [NB-1:0]      cs;
        logic [BW_W-1:0]    width;
        logic               err;
    } state_t;

    state_t st_d, st_q;

    logic [BASE_W-1:0] addr_hi;
    logic [NB-1:0]     hits;
    logic              any_hit, multi_hit;
    logic [IDX_W-1:0]  hit_idx;
    logic              flt_evt;
    fault_e            flt_code;
    logic              log_clr;

    assign addr_hi = req_addr_i[ADDR_W-1 -: BASE_W];
    assign log_clr = cfg_we_i && (cfg_sel_i == CLR_SEL);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        pbd_bank_match u_match (
            .base_i    (st_q.cfg[b].base),
            .size_i    (st_q.cfg[b].size),
            .usage_i   (st_q.cfg[b].usage),
            .addr_hi_i (addr_hi),
            .hit_o     (hits[b])
        );
    end

    pbd_resolve #(.NB(NB)) u_resolve (
        .hits_i  (hits),
        .any_o   (any_hit),
        .multi_o (multi_hit),
        .idx_o   (hit_idx)
    );

    always_comb begin
        bank_cfg_t sel_cfg;
        st_d     = st_q;
        st_d.cs    = '0;
        st_d.width = '0;
        st_d.err   = 1'b0;
        flt_evt  = 1'b0;
        flt_code = FLT_NONE;
        sel_cfg  = st_q.cfg[hit_idx];

        if (cfg_we_i && (cfg_sel_i < CLR_SEL)) begin
            st_d.cfg[cfg_sel_i[IDX_W-1:0]] = bank_cfg_t'(cfg_wdata_i);
        end

        if (req_valid_i && any_hit) begin
            if (multi_hit) begin
                flt_evt  = 1'b1;
                flt_code = FLT_OVERLAP;
            end else if (req_we_i && sel_cfg.usage == USE_RO) begin
                flt_evt  = 1'b1;
                flt_code = FLT_WPROT;
            end else if (!req_we_i && sel_cfg.usage == USE_WO) begin
                flt_evt  = 1'b1;
                flt_code = FLT_RPROT;
            end else begin
                st_d.cs[hit_idx] = 1'b1;
                st_d.width       = sel_cfg.width;
            end
        end
        st_d.err = flt_evt;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    pbd_err_log #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_log (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .clr_i        (log_clr),
        .evt_i        (flt_evt),
        .code_i       (flt_code),
        .bank_i       (hit_idx),
        .addr_i       (req_addr_i),
        .err_addr_o   (err_addr_o),
        .err_status_o (err_status_o)
    );

    assign cs_o        = st_q.cs;
    assign bus_width_o = st_q.width;
    assign err_o       = st_q.err;

    a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cs_o));

    a_r2_width_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_o == '0) |-> (bus_width_o == '0));

    a_r5_err_blocks_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> (cs_o == '0));

    a_r5_overlap_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && $countones(hits) > 1) |=> (err_o && cs_o == '0));

    a_r10_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_valid_i |=> (cs_o == '0 && !err_o));

endmodule

// File: tb/tb_periph_bank_decoder.sv
module tb_periph_bank_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_sel = '0;
    logic [18:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  cs;
    logic [1:0]  bw;
    logic        err;
    logic [31:0] err_addr;
    logic [5:0]  err_status;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    periph_bank_decoder dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_we_i     (cfg_we),
        .cfg_sel_i    (cfg_sel),
        .cfg_wdata_i  (cfg_wdata),
        .req_valid_i  (req_valid),
        .req_we_i     (req_we),
        .req_addr_i   (req_addr),
        .cs_o         (cs),
        .bus_width_o  (bw),
        .err_o        (err),
        .err_addr_o   (err_addr),
        .err_status_o (err_status)
    );

    // {addr, we, expected cs, expected width, expected err pulse}
    localparam int NV = 14;
    localparam logic [43:0] VEC [NV] = '{
        {32'h0001_2345, 1'b0, 8'h01, 2'b00, 1'b0},  // R2 bank0
        {32'h01AB_CDEF, 1'b1, 8'h00, 2'b00, 1'b1},  // R6 write to read-only
        {32'h01AB_CDEF, 1'b0, 8'h02, 2'b01, 1'b0},  // R3 16 MB bank, R2 width
        {32'h0205_0000, 1'b1, 8'h04, 2'b10, 1'b0},  // R2 write-only written
        {32'h0200_0000, 1'b0, 8'h00, 2'b00, 1'b1},  // R7 read from write-only
        {32'h0A2F_FFFF, 1'b0, 8'h08, 2'b10, 1'b0},  // R3 masked base bit
        {32'h0A40_0000, 1'b0, 8'h00, 2'b00, 1'b0},  // R4 no match
        {32'h3001_0000, 1'b0, 8'h00, 2'b00, 1'b0},  // R4 disabled bank
        {32'h4000_0010, 1'b1, 8'h00, 2'b00, 1'b1},  // R5 overlap
        {32'hF800_0000, 1'b0, 8'h80, 2'b00, 1'b0},  // R3 128 MB bottom
        {32'hFFFF_FFFC, 1'b1, 8'h80, 2'b00, 1'b0},  // R3 128 MB top
        {32'h0010_0000, 1'b0, 8'h00, 2'b00, 1'b0},  // R3 past 1 MB bank
        {32'h00FF_FFFF, 1'b0, 8'h00, 2'b00, 1'b0},  // R3 below 16 MB bank
        {32'h0A1F_FFFF, 1'b0, 8'h00, 2'b00, 1'b0}   // R3 below 2 MB bank
    };

    function automatic logic [18:0] mk(input logic [11:0] base, input logic [2:0] size,
                                       input logic [1:0] usage, input logic [1:0] width);
        return {base, size, usage, width};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [3:0] sel, input logic [18:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_req(input logic [31:0] a, input logic w);
        @(negedge clk);
        req_valid = 1'b1; req_we = w; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cs", cs, 0);
        chk("R1 width", bw, 0);
        chk("R1 err", err, 0);
        chk("R1 err_addr", err_addr, 0);
        chk("R1 err_status", err_status, 0);

        wr_cfg(0, mk(12'h000, 3'd0, 2'b11, 2'b00));
        wr_cfg(1, mk(12'h010, 3'd4, 2'b01, 2'b01));
        wr_cfg(2, mk(12'h020, 3'd0, 2'b10, 2'b10));
        wr_cfg(3, mk(12'h0A3, 3'd1, 2'b11, 2'b10));
        wr_cfg(4, mk(12'h300, 3'd0, 2'b00, 2'b01));
        wr_cfg(5, mk(12'h400, 3'd0, 2'b11, 2'b01));
        wr_cfg(6, mk(12'h400, 3'd0, 2'b11, 2'b10));
        wr_cfg(7, mk(12'hFFF, 3'd7, 2'b11, 2'b00));

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i][43:12], VEC[i][11]);
            chk($sformatf("vec%0d cs", i), cs, VEC[i][10:3]);
            chk($sformatf("vec%0d width", i), bw, VEC[i][2:1]);
            chk($sformatf("vec%0d err", i), err, VEC[i][0]);
        end

        // R8: first fault (write to bank1) kept, later faults set overflow
        chk("R8 err_addr first", err_addr, 32'h01AB_CDEF);
        chk("R8 err_status ovf", err_status, 6'h26);

        // R9: clear via select 8
        wr_cfg(4'd8, '0);
        chk("R9 cleared addr", err_addr, 0);
        chk("R9 cleared status", err_status, 0);

        // R5: overlap logged alone with lowest bank 5
        do_req(32'h4000_0010, 1'b0);
        chk("R5 err pulse", err, 1);
        chk("R5 cs dropped", cs, 0);
        chk("R5 status", err_status, 6'h15);
        chk("R5 addr", err_addr, 32'h4000_0010);

        // R10: address present but valid low
        @(negedge clk);
        req_valid = 1'b0; req_we = 1'b0; req_addr = 32'h0001_0000;
        @(negedge clk);
        chk("R10 cs idle", cs, 0);
        chk("R10 err idle", err, 0);

        // R4/R9: enabling bank4 makes it match from the next request
        wr_cfg(4, mk(12'h300, 3'd0, 2'b11, 2'b01));
        do_req(32'h3001_0000, 1'b0);
        chk("R4 enabled bank cs", cs, 8'h10);
        chk("R4 enabled width", bw, 2'b01);

        // R7: usage 11 permits read and write on bank0
        do_req(32'h000F_FFFF, 1'b1);
        chk("R7 rw write cs", cs, 8'h01);

        // R9: clear and fault in same cycle logs the fault first
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 4'd8;
        req_valid = 1'b1; req_we = 1'b0; req_addr = 32'h0200_0004;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R9 clear+fault status", err_status, 6'h0B);
        chk("R9 clear+fault addr", err_addr, 32'h0200_0004);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule